// File: doc/BRIEF.md
# Programmable down-counting interval timer

This block is a 32-bit down-counter with a small register port and one interrupt line. Software picks the counter size (16 or 32 bits), divides the input tick by 1, 16 or 256, and chooses one of three behaviours. In free-running mode the counter wraps to the all-ones value of its size. In periodic mode it wraps to a programmed reload value. In one-shot mode it stops at zero. The interrupt fires when the count reaches zero and stays set until software clears it.

The reload value can be set in two ways. An immediate load also restarts the count. A background load changes only the value used at the next wrap. Register writes take effect on the clock edge that samples them. Reads are combinational from the current register state.

Top module: `ivtimer`

## Requirements
- R1: After reset, the control register reads 0x20 (interrupt enable only). The reload value, current value, raw flag and `irq` all read 0.
- R2: Control bit 7 enables counting. While it is clear, ticks leave the current value unchanged. While it is set, each count-enable pulse lowers the value by one.
- R3: Control bits [3:2] set the prescale: 00 counts every tick, 01 every 16th tick, 10 every 256th tick, and 11 every tick. A control write restarts the prescale phase, so the first count comes on the N-th tick after the write.
- R4: With periodic mode set (control bit 6), a count at value 0 reloads the counter from the stored reload value.
- R5: With periodic mode clear, a count at value 0 reloads 0xFFFFFFFF when control bit 1 is set (32-bit size), or 0xFFFF when it is clear (16-bit size). In 16-bit size, a load keeps only the low 16 bits.
- R6: With one-shot mode set (control bit 0), the counter holds at 0 once it gets there. A write to the load register starts it again.
- R7: A write to offset 0 (load) sets the reload value and the current value together. A write to offset 6 (background load) sets only the reload value. Reads of offset 0 and offset 6 both return the reload value.
- R8: Offset 1 reads the current value. Writes to offset 1 have no effect.
- R9: The raw flag, read at offset 4 bit 0, is set by the count that takes the value from 1 to 0. A write of any data to offset 3 clears it.
- R10: Offset 5 returns the raw flag when control bit 5 (interrupt enable) is set and 0 when it is clear. `irq` follows the offset-5 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one clock wide, fed into the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word offset, used for both reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt: raw flag AND interrupt enable |

## Verification
Register writes become visible on the edge that samples `wr_en`, so the bench reads back on the following falling edge. A tick held high for one clock changes the current value, the raw flag and `irq` at that same rising edge. The expected value after k counts is worked out arithmetically: for periodic mode it is L minus (k mod (L+1)), and for free-running mode it is the size maximum once the count passes zero. Prescale checks count exactly N-1 ticks with no change and then one more tick, so an early or late pulse shows up at that single sample.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned PS_W    = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CTRL_W  = 8;

  localparam int unsigned CB_ONESHOT  = 0;
  localparam int unsigned CB_SIZE32   = 1;
  localparam int unsigned CB_PS_LO    = 2;
  localparam int unsigned CB_IE       = 5;
  localparam int unsigned CB_PERIODIC = 6;
  localparam int unsigned CB_ENABLE   = 7;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  typedef enum logic [ADDR_W-1:0] {
    OFS_LOAD   = 3'd0,
    OFS_VALUE  = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_CLEAR  = 3'd3,
    OFS_RAW    = 3'd4,
    OFS_MASKED = 3'd5,
    OFS_BGLOAD = 3'd6,
    OFS_NONE   = 3'd7
  } ofs_e;

  // Terminal phase of the prescaler for a select code
  function automatic logic [PS_W-1:0] ps_last(input logic [1:0] sel);
    case (sel)
      2'b01:   ps_last = PS_W'(15);
      2'b10:   ps_last = PS_W'(255);
      default: ps_last = '0;
    endcase
  endfunction

  // Live bits of the counter for the chosen size
  function automatic logic [CNT_W-1:0] size_mask(input logic size32);
    size_mask = size32 ? {CNT_W{1'b1}} : CNT_W'({SHORT_W{1'b1}});
  endfunction

  // Value taken after a count at zero
  function automatic logic [CNT_W-1:0] wrap_value(input logic periodic,
                                                  input logic size32,
                                                  input logic [CNT_W-1:0] reload);
    wrap_value = periodic ? (reload & size_mask(size32)) : size_mask(size32);
  endfunction

  function automatic logic [CNT_W-1:0] dec_value(input logic [CNT_W-1:0] v,
                                                 input logic size32);
    dec_value = (v - CNT_W'(1)) & size_mask(size32);
  endfunction
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              ctrl_wr,
  output logic              load_wr,
  output logic              clr_wr
);
  logic bg_wr;

  assign ctrl_wr = wr_en && (addr == OFS_CTRL);
  assign load_wr = wr_en && (addr == OFS_LOAD);
  assign bg_wr   = wr_en && (addr == OFS_BGLOAD);
  assign clr_wr  = wr_en && (addr == OFS_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RESET;
      reload <= '0;
    end else begin
      if (ctrl_wr)          ctrl   <= wr_data[CTRL_W-1:0];
      if (load_wr || bg_wr) reload <= wr_data;
    end
  end
endmodule

// File: rtl/ivt_prescale.sv
module ivt_prescale
  import ivt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       cen
);
  logic [PS_W-1:0] phase;
  logic [PS_W-1:0] last;
  logic            at_last;

  assign last    = ps_last(sel);
  assign at_last = (phase >= last);
  assign cen     = tick && at_last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase <= '0;
    else if (tick)         phase <= at_last ? '0 : phase + PS_W'(1);
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             enable,
  input  logic             oneshot,
  input  logic             periodic,
  input  logic             size32,
  input  logic [CNT_W-1:0] reload,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] value,
  output logic             zero_evt
);
  logic             run;
  logic             at_zero;
  logic [CNT_W-1:0] next_dec;

  assign run      = cen && enable && !load_wr;
  assign at_zero  = (value == '0);
  assign next_dec = dec_value(value, size32);
  assign zero_evt = run && !at_zero && (next_dec == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load_wr) begin
      value <= load_data & size_mask(size32);
    end else if (run) begin
      if (!at_zero)     value <= next_dec;
      else if (!oneshot) value <= wrap_value(periodic, size32, reload);
    end
  end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  value;
  logic              ctrl_wr, load_wr, clr_wr;
  logic              cen, zero_evt;
  logic              raw;
  logic              masked;

  ivt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctrl(ctrl), .reload(reload), .ctrl_wr(ctrl_wr), .load_wr(load_wr),
    .clr_wr(clr_wr)
  );

  ivt_prescale u_ps (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(ctrl_wr),
    .sel(ctrl[CB_PS_LO+1:CB_PS_LO]), .cen(cen)
  );

  ivt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .cen(cen), .enable(ctrl[CB_ENABLE]),
    .oneshot(ctrl[CB_ONESHOT]), .periodic(ctrl[CB_PERIODIC]),
    .size32(ctrl[CB_SIZE32]), .reload(reload), .load_wr(load_wr),
    .load_data(wr_data), .value(value), .zero_evt(zero_evt)
  );

  // A zero reached in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n)        raw <= 1'b0;
    else if (zero_evt) raw <= 1'b1;
    else if (clr_wr)   raw <= 1'b0;
  end

  assign masked = raw && ctrl[CB_IE];
  assign irq    = masked;

  always_comb begin
    case (addr)
      OFS_LOAD, OFS_BGLOAD: rd_data = reload;
      OFS_VALUE:            rd_data = value;
      OFS_CTRL:             rd_data = CNT_W'(ctrl);
      OFS_RAW:              rd_data = CNT_W'(raw);
      OFS_MASKED:           rd_data = CNT_W'(masked);
      default:              rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk
  import ivt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cen,
  input logic [CTRL_W-1:0] ctrl,
  input logic [CNT_W-1:0]  value,
  input logic              load_wr,
  input logic              clr_wr,
  input logic              zero_evt,
  input logic              raw,
  input logic              irq
);
  a_r3_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    cen |-> tick);

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CB_ENABLE] && !load_wr) |=> $stable(value));

  a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CB_ONESHOT] && value == '0 && !load_wr) |=> value == '0);

  a_r9_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (raw && value == '0));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !zero_evt) |=> !raw);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl[CB_IE] && raw));
endmodule

bind ivtimer ivtimer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cen(cen), .ctrl(ctrl),
  .value(value), .load_wr(load_wr), .clr_wr(clr_wr), .zero_evt(zero_evt),
  .raw(raw), .irq(irq)
);

// File: tb/ivtimer_tb.sv
module ivtimer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ivtimer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                 .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s ofs %0d actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", req, irq, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(3'd2, 32'h20, "R1");
    chk(3'd0, 32'h0, "R1");
    chk(3'd1, 32'h0, "R1");
    chk(3'd4, 32'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2 disabled: ticks leave value unchanged
    wr(3'd0, 32'd9);
    ticks(5);
    chk(3'd1, 32'd9, "R2");

    // R4 and R9: periodic sweep, value = L - (k mod (L+1))
    for (int l = 1; l <= 6; l++) begin
      wr(3'd2, 32'h0);
      wr(3'd3, 32'h0);
      wr(3'd0, 32'(l));
      wr(3'd2, 32'hE2);
      for (int k = 1; k <= 2 * l + 3; k++) begin
        ticks(1);
        chk(3'd1, 32'(l - (k % (l + 1))), "R4");
        chk(3'd4, 32'(k >= l), "R9");
      end
    end

    // R9 clear, R10 masking
    wr(3'd3, 32'h1234);
    chk(3'd4, 32'h0, "R9");
    wr(3'd2, 32'h0);
    wr(3'd0, 32'd1);
    wr(3'd2, 32'hC2);
    ticks(1);
    chk(3'd4, 32'h1, "R10");
    chk(3'd5, 32'h0, "R10");
    chk_irq(1'b0, "R10");
    wr(3'd2, 32'h20);
    chk(3'd5, 32'h1, "R10");
    chk_irq(1'b1, "R10");
    wr(3'd3, 32'h0);
    chk_irq(1'b0, "R10");

    // R5 free-running 16-bit, load truncated
    wr(3'd0, 32'h12345);
    chk(3'd1, 32'h2345, "R5");
    wr(3'd0, 32'd3);
    wr(3'd2, 32'hA0);
    ticks(3);
    chk(3'd1, 32'd0, "R5");
    ticks(1);
    chk(3'd1, 32'hFFFF, "R5");
    ticks(1);
    chk(3'd1, 32'hFFFE, "R5");
    // R5 free-running 32-bit
    wr(3'd2, 32'h0);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA2);
    ticks(3);
    chk(3'd1, 32'hFFFFFFFF, "R5");

    // R6 one-shot holds at zero, load restarts
    wr(3'd2, 32'h0);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hE3);
    ticks(2);
    chk(3'd1, 32'd0, "R6");
    ticks(5);
    chk(3'd1, 32'd0, "R6");
    wr(3'd0, 32'd4);
    ticks(1);
    chk(3'd1, 32'd3, "R6");

    // R7 background load and readback; R8 value write ignored
    wr(3'd2, 32'h0);
    wr(3'd0, 32'd3);
    wr(3'd6, 32'd7);
    chk(3'd0, 32'd7, "R7");
    chk(3'd6, 32'd7, "R7");
    chk(3'd1, 32'd3, "R7");
    wr(3'd1, 32'd99);
    chk(3'd1, 32'd3, "R8");
    wr(3'd2, 32'hC2);
    ticks(3);
    chk(3'd1, 32'd0, "R7");
    ticks(1);
    chk(3'd1, 32'd7, "R7");

    // R3 prescale sweep over all select codes
    for (int s = 0; s < 4; s++) begin
      int n;
      n = (s == 1) ? 16 : (s == 2) ? 256 : 1;
      wr(3'd2, 32'h0);
      wr(3'd0, 32'd1000);
      wr(3'd2, 32'hC2 | 32'(s << 2));
      ticks(n - 1);
      chk(3'd1, 32'd1000, "R3");
      ticks(1);
      chk(3'd1, 32'd999, "R3");
      ticks(n);
      chk(3'd1, 32'd998, "R3");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule